// File: doc/BRIEF.md
# Host Transmit Endpoint Control Register

This block holds the control and status byte for one host-side transmit (OUT) endpoint. Software reads and writes the byte through a simple register port. The transaction engine feeds it handshake events: ACK, NAK, STALL, transaction error, a frame tick and the FIFO occupancy flag. From these it drives the token choice for the next transaction (SETUP or OUT), the data toggle, a FIFO flush strobe, a DMA abort strobe and an endpoint-halted flag.

A received STALL stops the endpoint on its own. It latches the stalled status, clears transmit-ready, and pulses both flush and DMA abort for one cycle. A bulk endpoint that keeps receiving NAKs for more frames than a programmed limit latches a time-out and halts. Three errors in a row latch an error status. All three status bits stay set until software writes them to 0. Writing the clear-toggle strobe, or setting the setup bit, resets the data toggle. An ACK completes the transaction: it clears transmit-ready and the setup bit, and flips the toggle.

Top module: `host_txep_ctrl`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and every output is 0.
- R2: Software read-back: bit 7 NAK time-out, bit 5 stalled, bit 4 setup, bit 2 error and bit 0 transmit-ready hold the written value. Bits 6 (clear toggle) and 3 (flush) always read 0. Bit 1 shows `fifo_occupied` one cycle late, and writes to bit 1 are ignored.
- R3: A write with bit 6 set, or with bit 4 set, forces `data_toggle` to 0 after that edge. This takes priority over an ACK in the same cycle.
- R4: An ACK clears transmit-ready and setup, and inverts `data_toggle`.
- R5: `tok_setup` equals the setup bit, so 1 selects a SETUP token and 0 selects an OUT token.
- R6: A STALL sets the stalled bit and clears transmit-ready. It also raises `fifo_flush` and `dma_abort` for exactly one cycle, after the edge that sees the STALL.
- R7: The stalled bit stays set until software writes 0 to bit 5.
- R8: Writing 1 to bit 3 gives a one-cycle `fifo_flush` pulse with no `dma_abort`.
- R9: On a bulk endpoint, NAK time-out (bit 7) sets on the `nak_limit`-th frame tick counted from the first NAK with no ACK in between. `ep_halted` then rises. A limit of 0 disables the time-out.
- R10: On a non-bulk endpoint, NAK time-out never sets from events.
- R11: An ACK, or a write that raises transmit-ready from 0, restarts both the NAK frame count and the consecutive-error count.
- R12: NAK time-out and its halt stay set until software writes 0 to bit 7.
- R13: The third consecutive error sets the error bit (bit 2) and clears transmit-ready. Fewer errors set nothing.
- R14: The error bit stays set until software writes 0 to bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_bulk | input | 1 | Endpoint is of bulk type |
| nak_limit | input | NAK_W | Frames of NAK allowed before time-out; 0 disables |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_data | output | 8 | Register read data |
| ev_ack | input | 1 | ACK handshake received |
| ev_nak | input | 1 | NAK handshake received |
| ev_stall | input | 1 | STALL handshake received |
| ev_err | input | 1 | Transaction error |
| frame_tick | input | 1 | Start-of-frame strobe |
| fifo_occupied | input | 1 | Transmit FIFO holds data |
| tok_setup | output | 1 | 1: send SETUP token, 0: send OUT token |
| data_toggle | output | 1 | Current data toggle |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| dma_abort | output | 1 | One-cycle DMA abort request |
| ep_halted | output | 1 | Endpoint halted by stall or NAK time-out |

## Verification
The assertions take for granted that the transaction engine reports at most one handshake outcome per cycle: ACK, NAK, STALL and error are mutually exclusive. They also assume that `is_bulk` and `nak_limit` do not change during a NAK run. The directed tasks pulse each event alone for a single cycle. They change the endpoint type and limit only while no NAK run is active and the register is idle.

// File: rtl/txep_pkg.sv
package txep_pkg;
  // Bit positions decoded by software; order is fixed.
  localparam int unsigned B_NAKTO = 7;
  localparam int unsigned B_CLRTG = 6;
  localparam int unsigned B_STALL = 5;
  localparam int unsigned B_SETUP = 4;
  localparam int unsigned B_FLUSH = 3;
  localparam int unsigned B_ERR   = 2;
  localparam int unsigned B_FNE   = 1;
  localparam int unsigned B_TXRDY = 0;
  localparam int unsigned REG_W   = 8;
endpackage

// File: rtl/txep_toggle.sv
module txep_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flip,
  output logic toggle
);
  always_ff @(posedge clk) begin
    if (rst)       toggle <= 1'b0;
    else if (clr)  toggle <= 1'b0;
    else if (flip) toggle <= ~toggle;
  end
endmodule

// File: rtl/txep_nak_timer.sv
module txep_nak_timer #(
  parameter int unsigned NAK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_bulk,
  input  logic [NAK_W-1:0] limit,
  input  logic             nak,
  input  logic             tick,
  input  logic             restart,
  input  logic             timed_out,
  output logic             hit
);
  localparam logic [NAK_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic [NAK_W-1:0] cnt_q;
  logic             active;
  logic [NAK_W:0]   cnt_inc;

  assign active  = (run_q | nak) & is_bulk & ~timed_out;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hit     = active & tick & (limit != '0) & (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (nak) run_q <= 1'b1;
      if (active && tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/txep_err_counter.sv
module txep_err_counter #(
  parameter int unsigned ERR_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic err,
  input  logic restart,
  output logic hit
);
  localparam int unsigned CW = $clog2(ERR_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(ERR_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = err & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || hit) cnt_q <= '0;
    else if (err)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/host_txep_ctrl.sv
module host_txep_ctrl #(
  parameter int unsigned NAK_W     = 5,
  parameter int unsigned ERR_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_bulk,
  input  logic [NAK_W-1:0] nak_limit,
  input  logic             cfg_wr_en,
  input  logic [7:0]       cfg_wr_data,
  output logic [7:0]       cfg_rd_data,
  input  logic             ev_ack,
  input  logic             ev_nak,
  input  logic             ev_stall,
  input  logic             ev_err,
  input  logic             frame_tick,
  input  logic             fifo_occupied,
  output logic             tok_setup,
  output logic             data_toggle,
  output logic             fifo_flush,
  output logic             dma_abort,
  output logic             ep_halted
);
  import txep_pkg::*;

  logic nakto_q, stall_q, setup_q, err_q, fne_q, txrdy_q;
  logic nakto_n, stall_n, setup_n, err_n, txrdy_n;
  logic flush_q, abort_q, halt_q;
  logic txrdy_rise, nak_release, nak_hit, err_hit, tog_clr;

  assign txrdy_rise  = cfg_wr_en & cfg_wr_data[B_TXRDY] & ~txrdy_q;
  assign nak_release = cfg_wr_en & ~cfg_wr_data[B_NAKTO] & nakto_q;
  assign tog_clr     = cfg_wr_en & (cfg_wr_data[B_CLRTG] | cfg_wr_data[B_SETUP]);

  txep_nak_timer #(.NAK_W(NAK_W)) u_nak (
    .clk      (clk),
    .rst      (rst),
    .is_bulk  (is_bulk),
    .limit    (nak_limit),
    .nak      (ev_nak),
    .tick     (frame_tick),
    .restart  (ev_ack | txrdy_rise | nak_release),
    .timed_out(nakto_q),
    .hit      (nak_hit)
  );

  txep_err_counter #(.ERR_LIMIT(ERR_LIMIT)) u_err (
    .clk    (clk),
    .rst    (rst),
    .err    (ev_err),
    .restart(ev_ack | txrdy_rise),
    .hit    (err_hit)
  );

  txep_toggle u_tog (
    .clk   (clk),
    .rst   (rst),
    .clr   (tog_clr),
    .flip  (ev_ack),
    .toggle(data_toggle)
  );

  // Event-driven sets win over a software write in the same cycle.
  always_comb begin
    nakto_n = cfg_wr_en ? cfg_wr_data[B_NAKTO] : nakto_q;
    if (nak_hit) nakto_n = 1'b1;

    stall_n = cfg_wr_en ? cfg_wr_data[B_STALL] : stall_q;
    if (ev_stall) stall_n = 1'b1;

    err_n = cfg_wr_en ? cfg_wr_data[B_ERR] : err_q;
    if (err_hit) err_n = 1'b1;

    setup_n = cfg_wr_en ? cfg_wr_data[B_SETUP] : setup_q;
    if (ev_ack) setup_n = 1'b0;

    txrdy_n = cfg_wr_en ? cfg_wr_data[B_TXRDY] : txrdy_q;
    if (ev_ack || ev_stall || err_hit) txrdy_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nakto_q <= 1'b0;
      stall_q <= 1'b0;
      setup_q <= 1'b0;
      err_q   <= 1'b0;
      fne_q   <= 1'b0;
      txrdy_q <= 1'b0;
      flush_q <= 1'b0;
      abort_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      nakto_q <= nakto_n;
      stall_q <= stall_n;
      setup_q <= setup_n;
      err_q   <= err_n;
      fne_q   <= fifo_occupied;
      txrdy_q <= txrdy_n;
      flush_q <= ev_stall | (cfg_wr_en & cfg_wr_data[B_FLUSH]);
      abort_q <= ev_stall;
      halt_q  <= nakto_n | stall_n;
    end
  end

  always_comb begin
    cfg_rd_data          = '0;
    cfg_rd_data[B_NAKTO] = nakto_q;
    cfg_rd_data[B_STALL] = stall_q;
    cfg_rd_data[B_SETUP] = setup_q;
    cfg_rd_data[B_ERR]   = err_q;
    cfg_rd_data[B_FNE]   = fne_q;
    cfg_rd_data[B_TXRDY] = txrdy_q;
  end

  assign tok_setup  = setup_q;
  assign fifo_flush = flush_q;
  assign dma_abort  = abort_q;
  assign ep_halted  = halt_q;
endmodule

// File: rtl/txep_ctrl_checker.sv
module txep_ctrl_checker #(
  parameter int unsigned NAK_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             is_bulk,
  input logic [NAK_W-1:0] nak_limit,
  input logic             cfg_wr_en,
  input logic [7:0]       cfg_wr_data,
  input logic [7:0]       cfg_rd_data,
  input logic             ev_ack,
  input logic             ev_nak,
  input logic             ev_stall,
  input logic             ev_err,
  input logic             frame_tick,
  input logic             fifo_occupied,
  input logic             tok_setup,
  input logic             data_toggle,
  input logic             fifo_flush,
  input logic             dma_abort,
  input logic             ep_halted
);
  AST_STALL_REACTION: assert property (@(posedge clk) disable iff (rst)
    ev_stall |=> (fifo_flush && dma_abort && cfg_rd_data[5] && !cfg_rd_data[0])); // R6

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (dma_abort && !ev_stall) |=> !dma_abort); // R6

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[5] && !(cfg_wr_en && !cfg_wr_data[5])) |=> cfg_rd_data[5]); // R7

  AST_CLR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && (cfg_wr_data[6] || cfg_wr_data[4])) |=> !data_toggle); // R3

  AST_ACK_FLIP: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && !(cfg_wr_en && (cfg_wr_data[6] || cfg_wr_data[4])))
      |=> (data_toggle != $past(data_toggle) && !cfg_rd_data[0] && !tok_setup)); // R4

  AST_FNE_MIRROR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cfg_rd_data[1] == $past(fifo_occupied))); // R2

  AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_data[6] && !cfg_rd_data[3]); // R2

  AST_NONBULK_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (!is_bulk && !cfg_rd_data[7] && !(cfg_wr_en && cfg_wr_data[7])) |=> !cfg_rd_data[7]); // R10

  AST_NAKTO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[7] && !(cfg_wr_en && !cfg_wr_data[7])) |=> (cfg_rd_data[7] && ep_halted)); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[2] && !(cfg_wr_en && !cfg_wr_data[2])) |=> cfg_rd_data[2]); // R14
endmodule

bind host_txep_ctrl txep_ctrl_checker #(.NAK_W(NAK_W)) u_chk (.*);

// File: tb/test_host_txep_ctrl.sv
module test_host_txep_ctrl;
  localparam int unsigned NAK_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             is_bulk = 1'b0;
  logic [NAK_W-1:0] nak_limit = '0;
  logic             cfg_wr_en = 1'b0;
  logic [7:0]       cfg_wr_data = '0;
  logic [7:0]       cfg_rd_data;
  logic             ev_ack = 1'b0, ev_nak = 1'b0, ev_stall = 1'b0, ev_err = 1'b0;
  logic             frame_tick = 1'b0, fifo_occupied = 1'b0;
  logic             tok_setup, data_toggle, fifo_flush, dma_abort, ep_halted;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_txep_ctrl #(.NAK_W(NAK_W)) i_host_txep_ctrl (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Inputs change at negedge; one call moves past one rising edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step();
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic pulse_ack();   ev_ack = 1'b1;   step(); ev_ack = 1'b0;   endtask
  task automatic pulse_nak();   ev_nak = 1'b1;   step(); ev_nak = 1'b0;   endtask
  task automatic pulse_err();   ev_err = 1'b1;   step(); ev_err = 1'b0;   endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      frame_tick = 1'b1; step(); frame_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1", "rd_data", cfg_rd_data, 8'h00);
    chk("R1", "outputs", {3'b0, tok_setup, data_toggle, fifo_flush, dma_abort, ep_halted}, 8'h00);
  endtask

  task automatic t_readback();
    wr(8'hB5);
    chk("R2", "readback", cfg_rd_data, 8'hB5);
    chk("R5", "tok_setup on", {7'b0, tok_setup}, 8'h01);
    wr(8'hFF);
    chk("R2", "strobe bits read 0, fne ignores write", cfg_rd_data, 8'hB5);
    fifo_occupied = 1'b1;
    step();
    chk("R2", "fne mirror", cfg_rd_data, 8'hB7);
    wr(8'h00);
    chk("R2", "cleared, fne kept", cfg_rd_data, 8'h02);
    chk("R5", "tok_setup off", {7'b0, tok_setup}, 8'h00);
    fifo_occupied = 1'b0;
    step();
    chk("R2", "fne follows low", cfg_rd_data, 8'h00);
  endtask

  task automatic t_toggle();
    pulse_ack();
    chk("R4", "ack flips to 1", {7'b0, data_toggle}, 8'h01);
    wr(8'h40);
    chk("R3", "clear strobe", {7'b0, data_toggle}, 8'h00);
    pulse_ack();
    chk("R4", "ack flips again", {7'b0, data_toggle}, 8'h01);
    wr(8'h11);
    chk("R3", "setup clears toggle", {7'b0, data_toggle}, 8'h00);
    chk("R5", "setup token", {7'b0, tok_setup}, 8'h01);
    pulse_ack();
    chk("R4", "ack ends setup txn", cfg_rd_data, 8'h00);
    chk("R4", "toggle after ack", {7'b0, data_toggle}, 8'h01);
    chk("R5", "out token", {7'b0, tok_setup}, 8'h00);
    wr(8'h40);
  endtask

  task automatic t_stall();
    wr(8'h01);
    ev_stall = 1'b1; step(); ev_stall = 1'b0;
    chk("R6", "status", cfg_rd_data, 8'h20);
    chk("R6", "flush/abort/halt", {5'b0, fifo_flush, dma_abort, ep_halted}, 8'h07);
    step();
    chk("R6", "pulses end", {6'b0, fifo_flush, dma_abort}, 8'h00);
    step();
    chk("R7", "stalled sticky", cfg_rd_data, 8'h20);
    wr(8'h01);
    chk("R7", "sw clears stall", cfg_rd_data, 8'h01);
    chk("R7", "halt drops", {7'b0, ep_halted}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_flush();
    wr(8'h08);
    chk("R8", "flush pulse only", {6'b0, fifo_flush, dma_abort}, 8'h02);
    chk("R8", "flush bit reads 0", cfg_rd_data, 8'h00);
    step();
    chk("R8", "flush one cycle", {7'b0, fifo_flush}, 8'h00);
  endtask

  task automatic t_nak();
    is_bulk = 1'b1; nak_limit = 5'd4;
    wr(8'h01);
    pulse_nak();
    ticks(3);
    chk("R9", "below limit", {7'b0, cfg_rd_data[7]}, 8'h00);
    pulse_ack();
    wr(8'h01);
    pulse_nak();
    ticks(3);
    chk("R11", "count restarted by ack", {7'b0, cfg_rd_data[7]}, 8'h00);
    ticks(1);
    chk("R9", "time-out at limit", {7'b0, cfg_rd_data[7]}, 8'h01);
    chk("R9", "halted", {7'b0, ep_halted}, 8'h01);
    ticks(5);
    chk("R12", "sticky", {cfg_rd_data[7], 6'b0, ep_halted}, 8'h81);
    wr(8'h00);
    chk("R12", "sw clears", {cfg_rd_data[7], 6'b0, ep_halted}, 8'h00);
    nak_limit = 5'd0;
    pulse_nak();
    ticks(40);
    chk("R9", "limit 0 disables", {7'b0, cfg_rd_data[7]}, 8'h00);
    pulse_ack();
    is_bulk = 1'b0; nak_limit = 5'd4;
    pulse_nak();
    ticks(10);
    chk("R10", "non-bulk no time-out", {7'b0, cfg_rd_data[7]}, 8'h00);
    pulse_ack();
    wr(8'h40);
  endtask

  task automatic t_err();
    wr(8'h01);
    pulse_err(); pulse_err();
    chk("R13", "two errors", cfg_rd_data, 8'h01);
    pulse_ack();
    wr(8'h01);
    pulse_err(); pulse_err();
    chk("R11", "ack restarted error run", cfg_rd_data, 8'h01);
    pulse_err();
    chk("R13", "third error", cfg_rd_data, 8'h04);
    step(); step();
    chk("R14", "error sticky", cfg_rd_data, 8'h04);
    wr(8'h00);
    chk("R14", "sw clears error", cfg_rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_readback();
    t_toggle();
    t_stall();
    t_flush();
    t_nak();
    t_err();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule